// File: doc/BRIEF.md
# GPIO Interrupt Front End with Noise Filter

This block sits between a set of GPIO-derived interrupt lines and a parent interrupt controller. Each line is first brought into the clock domain by a synchronizer. The synchronized level goes out unchanged for the data path. It also feeds a per-line noise filter and an event shaper, which produce the request sent to the parent. Software programs the block through a simple 32-bit register bus with four control words: a line mask, a detection-style select, a filter enable and one filter length shared by every line.

When a line is set to follow its level, its request copies the line's level. The level is the filtered one when the filter is on and the raw synchronized one when it is off. When a line is set to both-edge detection, its request idles high. Every level change the filter accepts drops the request low for one clock, so a parent that only detects falling edges sees one event for each rising or falling transition. Both-edge events depend on the filter: with the filter off on that line, no events are produced.

Top module: `gpio_irq_filter`

## Requirements
- R1: After reset the mask, mode and filter-enable words read 0, the filter-length word reads 0xFF, and every `irq_out` bit is 0.
- R2: A write to offset 0x90 (mask), 0x94 (mode) or 0x98 (filter enable) stores `bus_wdata` bit i for line i, and the word reads back with unused upper bits as 0. Offset 0x9C holds the filter length in the low 8 bits. Any other offset reads 0 and writes to it change nothing.
- R3: A line whose mask bit is 0 drives its `irq_out` bit to 0 whatever its input does. Setting the mask bit takes effect on the clock edge after the write edge.
- R4: With mode bit 0 and filter bit 0, `irq_out[i]` equals the input level, changing on the third rising edge after the input changes.
- R5: With mode bit 0 and filter bit 1, a new level is accepted only after the synchronized input has differed from the filtered level for L consecutive cycles (L = filter length, and 0 acts as 1). `irq_out[i]` changes on rising edge L+3 after the input change. A pulse shorter than L cycles never reaches the output.
- R6: With mode bit 1 and filter bit 1, `irq_out[i]` idles at 1. Each accepted change, rising or falling, makes it 0 for exactly one cycle, on rising edge L+2 after the input change.
- R7: With mode bit 1 and filter bit 0, `irq_out[i]` stays at 1 and no events are produced.
- R8: `gpio_level[i]` shows the raw input after the two-stage synchronizer, on the second rising edge after a change. It is never affected by the filter.
- R9: Each line is controlled only by its own bit in each word. A transition on one line leaves every other line's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| gpio_in | input | NUM_LINES | Asynchronous line inputs |
| gpio_level | output | NUM_LINES | Synchronized, unfiltered line levels |
| irq_out | output | NUM_LINES | Per-line requests toward the parent controller |

## Verification
Each input change is applied on a falling edge, and rising edges are counted from there. The synchronized level is due after 2 edges. The follow-the-level output is due after 3 edges unfiltered, or after L+3 edges when filtered. The both-edge low pulse falls on edge L+2 and ends on edge L+3. The bench samples one edge before and after each of these points at every step of a window, on the line that toggles and on all the others. Register writes take effect on their own edge, and the mask reaches the output one edge later. Reads are sampled 1 ns after the address settles.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    localparam int unsigned BUS_ADDR_W = 8;
    localparam int unsigned BUS_DATA_W = 32;

    localparam logic [BUS_ADDR_W-1:0] OFS_MASK   = 8'h90;
    localparam logic [BUS_ADDR_W-1:0] OFS_MODE   = 8'h94;
    localparam logic [BUS_ADDR_W-1:0] OFS_FILTER = 8'h98;
    localparam logic [BUS_ADDR_W-1:0] OFS_LENGTH = 8'h9C;

    typedef struct packed {
        logic mask;
        logic mode;
        logic filter;
        logic length;
    } reg_hit_t;

    function automatic reg_hit_t decode_offset(input logic [BUS_ADDR_W-1:0] addr);
        reg_hit_t hit;
        hit.mask   = (addr == OFS_MASK);
        hit.mode   = (addr == OFS_MODE);
        hit.filter = (addr == OFS_FILTER);
        hit.length = (addr == OFS_LENGTH);
        return hit;
    endfunction

endpackage

// File: rtl/gpirq_regs.sv
module gpirq_regs
    import gpirq_pkg::*;
#(
    parameter int unsigned LINES      = 24,
    parameter int unsigned LEN_W      = 8,
    parameter int unsigned LEN_RESET  = 255
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    output logic [LINES-1:0]      mask_o,
    output logic [LINES-1:0]      mode_o,
    output logic [LINES-1:0]      filter_o,
    output logic [LEN_W-1:0]      length_o
);

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [LINES-1:0] mode;
        logic [LINES-1:0] filter;
        logic [LEN_W-1:0] length;
    } ctrl_t;

    ctrl_t    ctrl_d, ctrl_q;
    reg_hit_t wr_hit, rd_hit;

    always_comb begin
        ctrl_d = ctrl_q;
        wr_hit = decode_offset(bus_addr);
        if (bus_wr) begin
            if (wr_hit.mask)   ctrl_d.mask   = bus_wdata[LINES-1:0];
            if (wr_hit.mode)   ctrl_d.mode   = bus_wdata[LINES-1:0];
            if (wr_hit.filter) ctrl_d.filter = bus_wdata[LINES-1:0];
            if (wr_hit.length) ctrl_d.length = bus_wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.mask   <= '0;
            ctrl_q.mode   <= '0;
            ctrl_q.filter <= '0;
            ctrl_q.length <= LEN_W'(LEN_RESET);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        rd_hit    = decode_offset(bus_addr);
        if (rd_hit.mask)   bus_rdata[LINES-1:0] = ctrl_q.mask;
        if (rd_hit.mode)   bus_rdata[LINES-1:0] = ctrl_q.mode;
        if (rd_hit.filter) bus_rdata[LINES-1:0] = ctrl_q.filter;
        if (rd_hit.length) bus_rdata[LEN_W-1:0] = ctrl_q.length;
    end

    assign mask_o   = ctrl_q.mask;
    assign mode_o   = ctrl_q.mode;
    assign filter_o = ctrl_q.filter;
    assign length_o = ctrl_q.length;

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK) |=> (mask_o == $past(bus_wdata[LINES-1:0])));

endmodule

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
    parameter int unsigned WIDTH  = 24,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpirq_line.sv
module gpirq_line #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic             mask_i,
    input  logic             both_i,
    input  logic             filter_i,
    input  logic [LEN_W-1:0] length_i,
    output logic             irq_o
);

    typedef struct packed {
        logic             held;
        logic [LEN_W-1:0] run;
        logic             req;
    } line_t;

    line_t            st_d, st_q;
    logic             accept;
    logic [LEN_W:0]   need;
    logic [LEN_W:0]   run_next;

    always_comb begin
        st_d     = st_q;
        accept   = 1'b0;
        need     = (length_i == '0) ? (LEN_W+1)'(1) : {1'b0, length_i};
        run_next = {1'b0, st_q.run} + (LEN_W+1)'(1);

        if (!filter_i) begin
            st_d.held = level_i;
            st_d.run  = '0;
        end else if (level_i == st_q.held) begin
            st_d.run  = '0;
        end else if (run_next >= need) begin
            st_d.held = level_i;
            st_d.run  = '0;
            accept    = 1'b1;
        end else begin
            st_d.run  = run_next[LEN_W-1:0];
        end

        if (both_i) begin
            st_d.req = mask_i & (filter_i ? ~accept : 1'b1);
        end else begin
            st_d.req = mask_i & (filter_i ? st_q.held : level_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.req;

    // R3
    masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_i |=> !irq_o);

    // R7
    both_unfiltered_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && both_i && !filter_i) |=> irq_o);

    // R5
    filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_i && level_i == st_q.held) |=> $stable(st_q.held));

endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpirq_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 24,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned LEN_RESET   = 255,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0]  gpio_in,
    output logic [NUM_LINES-1:0]  gpio_level,
    output logic [NUM_LINES-1:0]  irq_out
);

    logic [NUM_LINES-1:0] mask_w;
    logic [NUM_LINES-1:0] mode_w;
    logic [NUM_LINES-1:0] filter_w;
    logic [LEN_W-1:0]     length_w;
    logic [NUM_LINES-1:0] level_w;

    gpirq_regs #(
        .LINES     (NUM_LINES),
        .LEN_W     (LEN_W),
        .LEN_RESET (LEN_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mask_o    (mask_w),
        .mode_o    (mode_w),
        .filter_o  (filter_w),
        .length_o  (length_w)
    );

    gpirq_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (gpio_in),
        .sync_o  (level_w)
    );

    assign gpio_level = level_w;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        gpirq_line #(
            .LEN_W (LEN_W)
        ) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_i  (level_w[i]),
            .mask_i   (mask_w[i]),
            .both_i   (mode_w[i]),
            .filter_i (filter_w[i]),
            .length_i (length_w),
            .irq_o    (irq_out[i])
        );
    end

endmodule

// File: tb/gpio_irq_filter_test.sv
module gpio_irq_filter_test;

    localparam int NL = 4;
    localparam logic [7:0] A_MASK = 8'h90;
    localparam logic [7:0] A_MODE = 8'h94;
    localparam logic [7:0] A_FILT = 8'h98;
    localparam logic [7:0] A_LEN  = 8'h9C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] gpio_in = '0;
    logic [NL-1:0] gpio_level;
    logic [NL-1:0] irq_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    gpio_irq_filter #(.NUM_LINES(NL)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .gpio_in    (gpio_in),
        .gpio_level (gpio_level),
        .irq_out    (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    function automatic logic exp_line(input bit mode, input bit flt, input int ln,
                                      input int k, input logic oldv, input logic newv);
        if (!mode) return (k >= (flt ? ln + 3 : 3)) ? newv : oldv;
        if (flt)   return (k == ln + 2) ? 1'b0 : 1'b1;
        return 1'b1;
    endfunction

    task automatic run_case(input bit mode, input bit flt, input int len, input int line);
        int   ln;
        logic idle;
        string req;
        ln   = (len == 0) ? 1 : len;
        idle = mode;
        req  = !mode ? (flt ? "R5" : "R4") : (flt ? "R6" : "R7");
        wr(A_MODE, mode ? 32'hF : 32'h0);
        wr(A_FILT, flt ? 32'hF : 32'h0);
        wr(A_LEN, 32'(len));
        step(10);
        for (int e = 0; e < 2; e++) begin
            logic oldv;
            logic newv;
            oldv = (e == 0) ? 1'b0 : 1'b1;
            newv = ~oldv;
            gpio_in[line] = newv;
            for (int k = 1; k <= ln + 5; k++) begin
                step(1);
                chk(req, 32'(irq_out[line]), 32'(exp_line(mode, flt, ln, k, oldv, newv)));
                for (int j = 0; j < NL; j++) begin
                    if (j != line) chk("R9", 32'(irq_out[j]), 32'(idle));
                end
                if (k == 1) chk("R8", 32'(gpio_level[line]), 32'(oldv));
                if (k == 2) chk("R8", 32'(gpio_level[line]), 32'(newv));
            end
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset values
        rd_chk("R1", A_MASK, 32'h0);
        rd_chk("R1", A_MODE, 32'h0);
        rd_chk("R1", A_FILT, 32'h0);
        rd_chk("R1", A_LEN, 32'hFF);
        chk("R1", 32'(irq_out), 32'h0);

        // R2: register map
        @(negedge clk);
        wr(A_MASK, 32'hFFFF_FFFF);
        rd_chk("R2", A_MASK, 32'hF);
        wr(A_LEN, 32'h0000_1234);
        rd_chk("R2", A_LEN, 32'h34);
        wr(8'hA0, 32'hFFFF_FFFF);
        rd_chk("R2", 8'hA0, 32'h0);
        rd_chk("R2", A_MODE, 32'h0);
        rd_chk("R2", A_FILT, 32'h0);
        wr(A_FILT, 32'h5);
        rd_chk("R2", A_FILT, 32'h5);
        @(negedge clk);

        // R3: mask gating
        wr(A_FILT, 32'h0);
        wr(A_MASK, 32'h0);
        step(4);
        gpio_in = 4'b1010;
        step(6);
        chk("R3", 32'(irq_out), 32'h0);
        wr(A_MASK, 32'h2);
        chk("R3", 32'(irq_out), 32'h0);
        step(1);
        chk("R3", 32'(irq_out), 32'h2);
        gpio_in = '0;
        wr(A_MASK, 32'hF);
        step(8);

        // R4 to R9: sweep of modes, lengths and lines
        for (int line = 0; line < NL; line++) begin
            run_case(1'b0, 1'b0, 1, line);
            run_case(1'b0, 1'b1, 0, line);
            run_case(1'b0, 1'b1, 1, line);
            run_case(1'b0, 1'b1, 3, line);
            run_case(1'b1, 1'b1, 0, line);
            run_case(1'b1, 1'b1, 2, line);
            run_case(1'b1, 1'b1, 4, line);
            run_case(1'b1, 1'b0, 1, line);
        end

        // R5: short pulse is rejected by the filter, but R8 level still shows it
        wr(A_MODE, 32'h0);
        wr(A_FILT, 32'hF);
        wr(A_LEN, 32'd4);
        step(10);
        gpio_in[2] = 1'b1;
        step(2);
        chk("R8", 32'(gpio_level[2]), 32'h1);
        gpio_in[2] = 1'b0;
        for (int k = 0; k < 12; k++) begin
            step(1);
            chk("R5", 32'(irq_out[2]), 32'h0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule